// File: doc/BRIEF.md
# Tri-Code Correlator Bank

This block despreads a stream of signed chip samples against seventeen independent 2-bit codes. Each lane holds one accumulator. Its code either adds the sample, subtracts it, or leaves the accumulator untouched. Leaving it untouched lets a lane correlate against a zero chip. The low-power code preprocessing of a receiver depends on this.

A single mode input changes how codes reach the lanes. In parallel mode every lane reads its own slice of the code bus. This suits frame synchronization, scrambling-code search and despreading for multipath fingers. In chained mode only lane 0 reads the bus. Each later lane reuses the code that its neighbour applied one cycle earlier, so the bank behaves as a chip matched filter for slot timing.

A dump strobe captures every lane's total into an output register and restarts the lane. The captured value is scaled and clipped down to the narrow word the symbol-rate processor takes.

Top module: `corr_bank`

## Requirements
- R1: While `rst` is high and in the first cycle after it, every output word is 0 and `out_valid` is 0. Every internal code register resets to hold (2'b00).
- R2: A lane whose applied code is 2'b10 adds the sample to its accumulator. A lane whose applied code is 2'b11 subtracts it. Bit 1 of a code is the enable and bit 0 is the sign (1 means negate).
- R3: A lane whose applied code has bit 1 clear (2'b00 or 2'b01) keeps its accumulator unchanged. The sample has no effect on its later dump.
- R4: The 16-bit accumulators saturate at +32767 and -32768 rather than wrapping. Accumulation continues from the saturated value.
- R5: With `dump` high and `clear` low, each lane's output is loaded from the accumulation including that cycle's sample. The accumulator then restarts from 0, so back-to-back dumps each report a single cycle.
- R6: `out_valid` is high exactly in the cycle after a dump that is not overridden by clear. The output words do not change in any cycle in which `out_valid` is low.
- R7: In parallel mode (`mode`=0), lane k applies `code_bus[2k+1:2k]`.
- R8: In chained mode (`mode`=1), lane 0 applies `code_bus[1:0]`. Lane k>0 applies the code lane k-1 applied on the previous cycle. All other code bus bits are ignored.
- R9: `clear` zeroes all accumulators and discards that cycle's sample. It takes priority over `dump`: no output load and no `out_valid`.
- R10: Each output word is the accumulation arithmetically shifted right by 2, then clipped to the 6-bit signed range -32..31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 1 | 0 = parallel codes, 1 = chained codes |
| sample | input | 6 | Signed chip sample |
| code_bus | input | 34 | Seventeen 2-bit codes, lane k at bits 2k+1:2k |
| dump | input | 1 | Capture and restart all lanes |
| clear | input | 1 | Zero all accumulators |
| out_bus | output | 102 | Seventeen signed 6-bit results, lane k at bits 6k+5:6k |
| out_valid | output | 1 | One-cycle pulse after a dump |

## Verification
Two states are hard to reach from the ports. The first is a saturated accumulator: the bench gets there by driving a full-scale sample with a constant add code for more than a thousand cycles, in both polarities. The second is the chained delay line, whose codes live only inside the bank. The bench reaches it by feeding a varied code sequence on the lowest slice while driving the other bus bits with junk. A per-lane reference model then predicts which delayed code each lane applied, and the dumped totals reveal any lane that picked up the wrong code or the wrong cycle.

// File: rtl/corr_pkg.sv
package corr_pkg;
  typedef enum logic {
    MODE_PARALLEL = 1'b0,
    MODE_CHAINED  = 1'b1
  } bank_mode_t;

  typedef logic [1:0] tcode_t;
  localparam int CODE_EN_BIT  = 1;
  localparam int CODE_NEG_BIT = 0;
endpackage

// File: rtl/corr_fmt.sv
module corr_fmt #(
  parameter int IN_W      = 16,
  parameter int OUT_W     = 6,
  parameter int OUT_SHIFT = 2
) (
  input  logic signed [IN_W-1:0]  din,
  output logic        [OUT_W-1:0] dout
);
  localparam logic signed [IN_W-1:0] HI = IN_W'(2**(OUT_W-1) - 1);
  localparam logic signed [IN_W-1:0] LO = IN_W'(-(2**(OUT_W-1)));

  logic signed [IN_W-1:0] scaled;

  always_comb begin
    scaled = din >>> OUT_SHIFT;
    if (scaled > HI)      dout = HI[OUT_W-1:0];
    else if (scaled < LO) dout = LO[OUT_W-1:0];
    else                  dout = scaled[OUT_W-1:0];
  end
endmodule

// File: rtl/corr_elem.sv
module corr_elem
  import corr_pkg::*;
#(
  parameter int SAMP_W    = 6,
  parameter int ACC_W     = 16,
  parameter int OUT_W     = 6,
  parameter int OUT_SHIFT = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  tcode_t                   code,
  input  logic signed [SAMP_W-1:0] sample,
  input  logic                     dump,
  input  logic                     clear,
  output logic signed [ACC_W-1:0]  acc_o,
  output logic        [OUT_W-1:0]  res_o
);
  localparam logic signed [ACC_W:0] MAXV = (ACC_W+1)'(2**(ACC_W-1) - 1);
  localparam logic signed [ACC_W:0] MINV = (ACC_W+1)'(-(2**(ACC_W-1)));

  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] acc_nxt;
  logic signed [ACC_W:0]   ext, term, sum;
  logic        [OUT_W-1:0] res_d;

  always_comb begin
    ext  = {{(ACC_W+1-SAMP_W){sample[SAMP_W-1]}}, sample};
    term = code[CODE_NEG_BIT] ? -ext : ext;
    sum  = {acc_q[ACC_W-1], acc_q} + term;
    if (!code[CODE_EN_BIT]) acc_nxt = acc_q;
    else if (sum > MAXV)    acc_nxt = MAXV[ACC_W-1:0];
    else if (sum < MINV)    acc_nxt = MINV[ACC_W-1:0];
    else                    acc_nxt = sum[ACC_W-1:0];
  end

  corr_fmt #(.IN_W(ACC_W), .OUT_W(OUT_W), .OUT_SHIFT(OUT_SHIFT)) u_fmt (
    .din  (acc_nxt),
    .dout (res_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      res_o <= '0;
    end else if (clear) begin
      acc_q <= '0;
    end else if (dump) begin
      acc_q <= '0;
      res_o <= res_d;
    end else begin
      acc_q <= acc_nxt;
    end
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/corr_bank.sv
module corr_bank
  import corr_pkg::*;
#(
  parameter int N_ELEM    = 17,
  parameter int SAMP_W    = 6,
  parameter int ACC_W     = 16,
  parameter int OUT_W     = 6,
  parameter int OUT_SHIFT = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     mode,
  input  logic signed [SAMP_W-1:0] sample,
  input  logic [2*N_ELEM-1:0]      code_bus,
  input  logic                     dump,
  input  logic                     clear,
  output logic [N_ELEM*OUT_W-1:0]  out_bus,
  output logic                     out_valid
);
  localparam int CODE_BITS = 2 * N_ELEM;

  bank_mode_t                  mode_e;
  tcode_t                      code_q   [N_ELEM];
  tcode_t                      code_act [N_ELEM];
  logic [CODE_BITS-1:0]        code_act_flat;
  logic [N_ELEM*ACC_W-1:0]     acc_flat;

  assign mode_e = bank_mode_t'(mode);

  genvar k;
  generate
    for (k = 0; k < N_ELEM; k++) begin : g_lane
      if (k == 0) begin : g_head
        assign code_act[k] = code_bus[1:0];
      end else begin : g_tail
        assign code_act[k] = (mode_e == MODE_CHAINED) ? code_q[k-1]
                                                      : code_bus[2*k +: 2];
      end
      assign code_act_flat[2*k +: 2] = code_act[k];

      corr_elem #(
        .SAMP_W(SAMP_W), .ACC_W(ACC_W), .OUT_W(OUT_W), .OUT_SHIFT(OUT_SHIFT)
      ) u_elem (
        .clk    (clk),
        .rst    (rst),
        .code   (code_act[k]),
        .sample (sample),
        .dump   (dump),
        .clear  (clear),
        .acc_o  (acc_flat[k*ACC_W +: ACC_W]),
        .res_o  (out_bus[k*OUT_W +: OUT_W])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_ELEM; i++) code_q[i] <= 2'b00;
      out_valid <= 1'b0;
    end else begin
      for (int i = 0; i < N_ELEM; i++) code_q[i] <= code_act[i];
      out_valid <= dump && !clear;
    end
  end
endmodule

// File: rtl/corr_bank_chk.sv
module corr_bank_chk #(
  parameter int N_ELEM = 17,
  parameter int ACC_W  = 16,
  parameter int OUT_W  = 6
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    mode,
  input logic                    dump,
  input logic                    clear,
  input logic                    out_valid,
  input logic [N_ELEM*OUT_W-1:0] out_bus,
  input logic [2*N_ELEM-1:0]     code_act_flat,
  input logic [N_ELEM*ACC_W-1:0] acc_flat
);
  p_valid_follows_dump_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(dump && !clear)));

  p_out_held_r6: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !$past(rst)) |-> $stable(out_bus));

  p_clear_zeroes_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(clear) && !$past(rst)) |-> (acc_flat == '0));

  genvar k;
  generate
    for (k = 0; k < N_ELEM; k++) begin : g_chk
      p_hold_code_r3: assert property (@(posedge clk) disable iff (rst)
        (!clear && !dump && !code_act_flat[2*k+1])
          |=> (acc_flat[k*ACC_W +: ACC_W] == $past(acc_flat[k*ACC_W +: ACC_W])));
      if (k > 0) begin : g_chain
        p_chain_delay_r8: assert property (@(posedge clk) disable iff (rst)
          (mode && !$past(rst))
            |-> (code_act_flat[2*k +: 2] == $past(code_act_flat[2*(k-1) +: 2])));
      end
    end
  endgenerate
endmodule

bind corr_bank corr_bank_chk #(.N_ELEM(N_ELEM), .ACC_W(ACC_W), .OUT_W(OUT_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .mode          (mode),
  .dump          (dump),
  .clear         (clear),
  .out_valid     (out_valid),
  .out_bus       (out_bus),
  .code_act_flat (code_act_flat),
  .acc_flat      (acc_flat)
);

// File: tb/corr_bank_test.sv
`timescale 1ns/1ps
module corr_bank_test;
  localparam int N = 17;
  localparam int OW = 6;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              mode = 1'b0;
  logic signed [5:0] sample = '0;
  logic [2*N-1:0]    code_bus = '0;
  logic              dump = 1'b0;
  logic              clear = 1'b0;
  logic [N*OW-1:0]   out_bus;
  logic              out_valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int         exp_acc [N];
  int         exp_out [N];
  logic [1:0] prev    [N];
  logic       exp_valid;

  always #10 clk = ~clk;

  corr_bank uut (
    .clk(clk), .rst(rst), .mode(mode), .sample(sample), .code_bus(code_bus),
    .dump(dump), .clear(clear), .out_bus(out_bus), .out_valid(out_valid)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    for (int k = 0; k < N; k++)
      chk($sformatf("%s lane %0d", tag, k), int'($signed(out_bus[k*OW +: OW])), exp_out[k]);
    chk({tag, " valid (R6)"}, int'(out_valid), int'(exp_valid));
  endtask

  task automatic step(input int smp, input logic [2*N-1:0] cb, input logic md,
                      input logic dmp, input logic clr);
    logic [1:0] cur [N];
    sample = smp[5:0]; code_bus = cb; mode = md; dump = dmp; clear = clr;
    for (int k = 0; k < N; k++)
      cur[k] = (md && k > 0) ? prev[k-1] : cb[2*k +: 2];
    for (int k = 0; k < N; k++) begin
      int t;
      if (clr) exp_acc[k] = 0;
      else begin
        t = exp_acc[k];
        if (cur[k][1]) t = cur[k][0] ? t - smp : t + smp;
        if (t > 32767) t = 32767;
        if (t < -32768) t = -32768;
        if (dmp) begin
          int s;
          s = t >>> 2;
          if (s > 31) s = 31;
          if (s < -32) s = -32;
          exp_out[k] = s;
          exp_acc[k] = 0;
        end else exp_acc[k] = t;
      end
    end
    for (int k = 0; k < N; k++) prev[k] = cur[k];
    exp_valid = dmp && !clr;
    @(posedge clk); #1;
  endtask

  function automatic logic [2*N-1:0] par_codes(input int variant);
    logic [2*N-1:0] b;
    for (int k = 0; k < N; k++) begin
      case ((k + variant) % 4)
        0: b[2*k +: 2] = 2'b10;
        1: b[2*k +: 2] = 2'b11;
        2: b[2*k +: 2] = 2'b00;
        default: b[2*k +: 2] = 2'b01;
      endcase
    end
    return b;
  endfunction

  task automatic t_reset;
    for (int k = 0; k < N; k++) begin
      exp_acc[k] = 0; exp_out[k] = 0; prev[k] = 2'b00;
    end
    exp_valid = 1'b0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check_all("R1 during reset");
    rst = 1'b0;
    @(posedge clk); #1;
    check_all("R1 after reset");
  endtask

  task automatic t_parallel;
    int smp [6] = '{5, -7, 31, -32, 12, 19};
    for (int r = 0; r < 8; r++)
      for (int i = 0; i < 6; i++)
        step(smp[i], par_codes(r % 2), 1'b0, (r == 7 && i == 5), 1'b0);
    check_all("R2 R3 R7 parallel dump");
  endtask

  task automatic t_hold;
    logic [2*N-1:0] holds;
    for (int k = 0; k < N; k++) holds[2*k +: 2] = (k % 2) ? 2'b01 : 2'b00;
    step(24, {N{2'b10}}, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 10; i++) step(31 - i, holds, 1'b0, 1'b0, 1'b0);
    step(0, holds, 1'b0, 1'b1, 1'b0);
    check_all("R3 hold codes ignore samples");
  endtask

  task automatic t_dump_restart;
    step(20, {N{2'b10}}, 1'b0, 1'b0, 1'b0);
    check_all("R6 outputs held, no valid");
    step(8, {N{2'b10}}, 1'b0, 1'b1, 1'b0);
    check_all("R5 dump includes dump-cycle sample");
    chk("R5 lane0 value 28>>2", int'($signed(out_bus[OW-1:0])), 7);
    step(16, {N{2'b11}}, 1'b0, 1'b1, 1'b0);
    check_all("R5 back-to-back dump restarts");
    chk("R5 lane0 value -16>>2", int'($signed(out_bus[OW-1:0])), -4);
    step(3, {N{2'b10}}, 1'b0, 1'b0, 1'b0);
    chk("R6 valid single pulse", int'(out_valid), 0);
  endtask

  task automatic t_saturate;
    for (int i = 0; i < 1100; i++) step(31, {N{2'b10}}, 1'b0, 1'b0, 1'b0);
    step(31, {N{2'b10}}, 1'b0, 1'b1, 1'b0);
    check_all("R4 R10 positive saturation");
    chk("R10 clip high", int'($signed(out_bus[OW-1:0])), 31);
    for (int i = 0; i < 1100; i++) step(-32, {N{2'b10}}, 1'b0, 1'b0, 1'b0);
    step(31, {N{2'b10}}, 1'b0, 1'b0, 1'b0);
    step(0, {N{2'b10}}, 1'b0, 1'b1, 1'b0);
    check_all("R4 negative saturation then recovery");
    step(26, {N{2'b10}}, 1'b0, 1'b0, 1'b0);
    step(14, {N{2'b10}}, 1'b0, 1'b1, 1'b0);
    chk("R10 unclipped shift 40>>2", int'($signed(out_bus[OW-1:0])), 10);
  endtask

  task automatic t_chain;
    logic [1:0] seq [7] = '{2'b10, 2'b11, 2'b10, 2'b00, 2'b11, 2'b01, 2'b10};
    for (int i = 0; i < 30; i++) begin
      logic [2*N-1:0] b;
      b = {{(2*N-2){1'b1}}, 2'b00} ^ {{(N-1){2'b10}}, seq[i % 7]};
      step((i * 7) % 50 - 20, b, 1'b1, (i == 29), 1'b0);
    end
    check_all("R8 chained delay line");
  endtask

  task automatic t_clear;
    for (int i = 0; i < 3; i++) step(10, {N{2'b10}}, 1'b0, 1'b0, 1'b0);
    step(9, {N{2'b10}}, 1'b0, 1'b1, 1'b1);
    check_all("R9 clear overrides dump");
    chk("R9 no valid on clear+dump", int'(out_valid), 0);
    step(12, {N{2'b10}}, 1'b0, 1'b1, 1'b0);
    check_all("R9 only post-clear samples");
    chk("R9 lane0 value 12>>2", int'($signed(out_bus[OW-1:0])), 3);
  endtask

  initial begin
    #4ms;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_parallel();
    t_hold();
    t_dump_restart();
    t_saturate();
    t_chain();
    t_clear();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule